// File: doc/BRIEF.md
# Recursive Reed–Solomon Error Magnitude Solver

This block finds the error values of a Reed–Solomon code word over GF(2^M) once the error positions are known. The position search supplies the error locator values X_1..X_ν in its field representation. The syndrome stage supplies the syndromes S_j, where S_j is the sum over the errors of Y_i·X_i^j. From these two inputs the block returns one magnitude Y_i for each locator. It never takes the coefficients of the error-locator polynomial, and it reads only the first ν syndromes.

The computation is a deep combinational datapath. It runs in three steps.
- A preparation step builds running products of locator differences, together with their inverses.
- An elimination step rewrites the syndromes one locator at a time. After stage r, the contribution of X_r has been removed.
- A back-substitution step starts at the last locator. Each earlier magnitude is computed from the magnitudes already solved.

A single register stage holds the result so that the decoder around the block sees a fixed latency of one clock.

Top module: `rsm_solver`

## Requirements
- R1: `out_valid` equals the value `in_valid` had at the previous rising clock edge. While `rst_n` is low, `out_valid`, `out_nu` and every `out_mag` slot read zero.
- R2: The inputs must meet three conditions. `in_valid` is high. The first ν locators are nonzero and pairwise distinct. Slot j of `in_syn` (bits j·M+M-1 down to j·M) carries S_{j+1} = Σ Y_i·X_i^{j+1}. When these hold, `out_mag` slot i (bits i·M+M-1 down to i·M) equals Y_i for every i below ν one cycle later. Slot i of `in_loc` holds X_{i+1} in the same bit position. The field is GF(2^M) in polynomial basis, reduced by the parameter POLY (default M=8, POLY=0x11D).
- R3: Every `out_mag` slot at index ν or above reads zero.
- R4: Locator slots and syndrome slots at index ν or above have no effect on any output.
- R5: An `in_nu` value above T is treated as T. `out_nu` reports the ν that was applied. When `in_nu` is 0, every magnitude slot reads zero.
- R6: While `in_valid` is low, `out_mag` and `out_nu` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Inputs on this cycle are to be solved |
| in_nu | input | $clog2(T+1) | Number of errors ν, clamped to T |
| in_loc | input | T·M | Locator values, slot i holds X_{i+1} |
| in_syn | input | T·M | Syndromes, slot j holds S_{j+1} |
| out_valid | output | 1 | Result registered from a valid input |
| out_nu | output | $clog2(T+1) | Applied ν of the held result |
| out_mag | output | T·M | Magnitudes, slot i holds Y_{i+1}; zero beyond ν |

## Verification
The embedded checks assume that whenever `in_valid` is high, the active locators are nonzero and distinct. Under that condition, recombining the solved magnitudes with the locators reproduces S_1. A repeated or zero locator makes a denominator vanish, so the check is gated on a locator-sanity term.

The stimulus draws distinct exponents of the primitive element to build the locators. It picks the magnitudes first and forms the syndromes from them with log/antilog tables. Random values go only into slots at or beyond ν, or onto inputs during idle cycles.

// File: rtl/rsm_pkg.sv
package rsm_pkg;

  localparam int SYM_MAX = 8;

  typedef logic [SYM_MAX-1:0] sym_t;
  typedef logic [SYM_MAX:0]   poly_t;

  // Shift-and-add product in GF(2^m), m <= SYM_MAX, reduced by poly.
  function automatic sym_t gf_mul(input sym_t a, input sym_t b, input int m, input poly_t poly);
    sym_t  p;
    sym_t  mask;
    poly_t one;
    one  = poly_t'(1);
    mask = sym_t'((one << m) - one);
    p    = '0;
    for (int k = SYM_MAX - 1; k >= 0; k--) begin
      if (k < m) begin
        logic hi;
        hi = p[m-1];
        p  = (p << 1) & mask;
        if (hi) p = p ^ (poly[SYM_MAX-1:0] & mask);
        if (b[k]) p = p ^ a;
      end
    end
    return p;
  endfunction

  // Inverse as a^(2^m - 2); zero maps to zero.
  function automatic sym_t gf_inv(input sym_t a, input int m, input poly_t poly);
    sym_t x;
    sym_t r;
    x = a;
    r = sym_t'(1);
    for (int k = 1; k < SYM_MAX; k++) begin
      if (k < m) begin
        x = gf_mul(x, x, m, poly);
        r = gf_mul(r, x, m, poly);
      end
    end
    return (a == '0) ? '0 : r;
  endfunction

  // Position of weight (row r, locator i > r) in the flattened triangle.
  function automatic int tri_idx(input int r, input int i, input int t);
    return r * t - (r * (r + 1)) / 2 + (i - r - 1);
  endfunction

endpackage

// File: rtl/rsm_prep.sv
module rsm_prep import rsm_pkg::*; #(
  parameter int M    = 8,
  parameter int T    = 4,
  parameter int POLY = 'h11D,
  localparam int NW  = T * (T - 1) / 2
) (
  input  logic [T-1:0][M-1:0]  loc,
  output logic [T-1:0][M-1:0]  dinv,
  output logic [NW-1:0][M-1:0] wt
);

  function automatic logic [M-1:0] fmul(input logic [M-1:0] a, input logic [M-1:0] b);
    return M'(gf_mul(sym_t'(a), sym_t'(b), M, poly_t'(POLY)));
  endfunction

  function automatic logic [M-1:0] finv(input logic [M-1:0] a);
    return M'(gf_inv(sym_t'(a), M, poly_t'(POLY)));
  endfunction

  // Row r, entry e stands for locator i = r + e:
  //   prod = X_i * prod over l < r of (X_i + X_l)
  for (genvar r = 0; r < T; r++) begin : g_lvl
    logic [T-r-1:0][M-1:0] prod;
    if (r == 0) begin : g_base
      assign prod = loc;
    end else begin : g_step
      for (genvar e = 0; e < T - r; e++) begin : g_ent
        assign prod[e] = fmul(g_lvl[r-1].prod[e+1], loc[r+e] ^ loc[r-1]);
      end
    end
    assign dinv[r] = finv(prod[0]);
    for (genvar e = 1; e < T - r; e++) begin : g_wt
      assign wt[tri_idx(r, r + e, T)] = prod[e];
    end
  end

endmodule

// File: rtl/rsm_refine.sv
module rsm_refine import rsm_pkg::*; #(
  parameter int M    = 8,
  parameter int T    = 4,
  parameter int POLY = 'h11D
) (
  input  logic [T-2:0][M-1:0] loc,
  input  logic [T-1:0][M-1:0] syn,
  output logic [T-1:0][M-1:0] lead
);

  function automatic logic [M-1:0] fmul(input logic [M-1:0] a, input logic [M-1:0] b);
    return M'(gf_mul(sym_t'(a), sym_t'(b), M, poly_t'(POLY)));
  endfunction

  // Row r holds syndromes with X_1..X_r stripped away: s'_j = s_{j+1} + X_r * s_j
  for (genvar r = 0; r < T; r++) begin : g_lvl
    logic [T-r-1:0][M-1:0] row;
    if (r == 0) begin : g_base
      assign row = syn;
    end else begin : g_step
      for (genvar j = 0; j < T - r; j++) begin : g_ent
        assign row[j] = g_lvl[r-1].row[j+1] ^ fmul(g_lvl[r-1].row[j], loc[r-1]);
      end
    end
    assign lead[r] = row[0];
  end

endmodule

// File: rtl/rsm_extract.sv
module rsm_extract import rsm_pkg::*; #(
  parameter int M    = 8,
  parameter int T    = 4,
  parameter int POLY = 'h11D,
  parameter int NUW  = 3,
  localparam int NW  = T * (T - 1) / 2
) (
  input  logic [T-1:0][M-1:0]  lead,
  input  logic [T-1:0][M-1:0]  dinv,
  input  logic [NW-1:0][M-1:0] wt,
  input  logic [NUW-1:0]       nu,
  output logic [T-1:0][M-1:0]  mag
);

  function automatic logic [M-1:0] fmul(input logic [M-1:0] a, input logic [M-1:0] b);
    return M'(gf_mul(sym_t'(a), sym_t'(b), M, poly_t'(POLY)));
  endfunction

  // Back substitution from the last slot down; each slot uses the ones above it.
  for (genvar r = 0; r < T; r++) begin : g_sol
    logic [M-1:0] num;
    always_comb begin
      num = lead[r];
      for (int i = r + 1; i < T; i++) begin
        num = num ^ fmul(wt[tri_idx(r, i, T)], mag[i]);
      end
    end
    assign mag[r] = (NUW'(r) < nu) ? fmul(num, dinv[r]) : '0;
  end

endmodule

// File: rtl/rsm_solver.sv
module rsm_solver import rsm_pkg::*; #(
  parameter int M     = 8,
  parameter int T     = 4,
  parameter int POLY  = 'h11D,
  localparam int NUW  = $clog2(T + 1),
  localparam int NW   = T * (T - 1) / 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [NUW-1:0]      in_nu,
  input  logic [T-1:0][M-1:0] in_loc,
  input  logic [T-1:0][M-1:0] in_syn,
  output logic                out_valid,
  output logic [NUW-1:0]      out_nu,
  output logic [T-1:0][M-1:0] out_mag
);

  function automatic logic [M-1:0] fmul(input logic [M-1:0] a, input logic [M-1:0] b);
    return M'(gf_mul(sym_t'(a), sym_t'(b), M, poly_t'(POLY)));
  endfunction

  logic [NUW-1:0]      nu_eff;
  logic [T-1:0][M-1:0] loc_m;
  logic [T-1:0][M-1:0] syn_m;
  logic [T-1:0][M-1:0] dinv;
  logic [NW-1:0][M-1:0] wt;
  logic [T-1:0][M-1:0] lead;
  logic [T-1:0][M-1:0] mag_c;

  assign nu_eff = (in_nu > NUW'(T)) ? NUW'(T) : in_nu;

  // Slots at or beyond nu are forced to zero before any arithmetic.
  for (genvar s = 0; s < T; s++) begin : g_mask
    assign loc_m[s] = (NUW'(s) < nu_eff) ? in_loc[s] : '0;
    assign syn_m[s] = (NUW'(s) < nu_eff) ? in_syn[s] : '0;
  end

  rsm_prep #(.M(M), .T(T), .POLY(POLY)) u_prep (
    .loc  (loc_m),
    .dinv (dinv),
    .wt   (wt)
  );

  rsm_refine #(.M(M), .T(T), .POLY(POLY)) u_refine (
    .loc  (loc_m[T-2:0]),
    .syn  (syn_m),
    .lead (lead)
  );

  rsm_extract #(.M(M), .T(T), .POLY(POLY), .NUW(NUW)) u_extract (
    .lead (lead),
    .dinv (dinv),
    .wt   (wt),
    .nu   (nu_eff),
    .mag  (mag_c)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_nu    <= '0;
      out_mag   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_nu  <= nu_eff;
        out_mag <= mag_c;
      end
    end
  end

  // Observation wires: locator sanity and recombined first syndrome.
  logic         loc_ok;
  logic [M-1:0] resyn1;
  always_comb begin
    loc_ok = 1'b1;
    resyn1 = '0;
    for (int a = 0; a < T; a++) begin
      resyn1 = resyn1 ^ fmul(mag_c[a], loc_m[a]);
      if (NUW'(a) < nu_eff) begin
        if (loc_m[a] == '0) loc_ok = 1'b0;
        for (int b = 0; b < a; b++) begin
          if (loc_m[a] == loc_m[b]) loc_ok = 1'b0;
        end
      end
    end
  end

  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R1
  idle_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R6
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_mag) && $stable(out_nu)));

  // R2
  resyn_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && loc_ok && nu_eff != '0) |-> (resyn1 == in_syn[0]));

  // R5
  nu_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_nu <= NUW'(T)));

  for (genvar k = 0; k < T; k++) begin : g_zchk
    // R3
    zero_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && NUW'(k) >= out_nu) |-> (out_mag[k] == '0));
  end

endmodule

// File: tb/test_rsm_solver.sv
module test_rsm_solver;

  localparam int M    = 8;
  localparam int T    = 4;
  localparam int POLY = 'h11D;
  localparam int NUW  = $clog2(T + 1);
  localparam int Q    = 1 << M;

  logic                clk = 1'b0;
  logic                rst_n;
  logic                in_valid;
  logic [NUW-1:0]      in_nu;
  logic [T-1:0][M-1:0] in_loc;
  logic [T-1:0][M-1:0] in_syn;
  logic                out_valid;
  logic [NUW-1:0]      out_nu;
  logic [T-1:0][M-1:0] out_mag;

  always #2 clk = ~clk;

  rsm_solver #(.M(M), .T(T), .POLY(POLY)) i_rsm_solver (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_nu(in_nu),
    .in_loc(in_loc), .in_syn(in_syn),
    .out_valid(out_valid), .out_nu(out_nu), .out_mag(out_mag)
  );

  int gexp [Q-1];
  int glog [Q];
  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  int    e_valid;
  int    e_nu;
  int    e_mag [T];
  string e_tag;

  function automatic int gmul(input int a, input int b);
    if (a == 0 || b == 0) return 0;
    return gexp[(glog[a] + glog[b]) % (Q - 1)];
  endfunction

  function automatic int gpow(input int a, input int e);
    if (a == 0) return 0;
    return gexp[(glog[a] * e) % (Q - 1)];
  endfunction

  task automatic chk(input string tag, input int act, input int expv, input string what);
    n_chk++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  task automatic compare();
    chk("R1", int'(out_valid), e_valid, "out_valid");
    chk("R5", int'(out_nu), e_nu, "out_nu");
    for (int k = 0; k < T; k++)
      chk((k < e_nu) ? e_tag : "R3", int'(out_mag[k]), e_mag[k], $sformatf("slot %0d", k));
  endtask

  // One valid input; garbage goes only into slots at or beyond nu.
  task automatic send(input int nu_req, input bit garbage, input string tag);
    int ne;
    int xs [T];
    int ys [T];
    @(negedge clk);
    compare();
    ne = (nu_req > T) ? T : nu_req;
    for (int i = 0; i < T; i++) begin
      xs[i] = 0;
      ys[i] = 0;
    end
    for (int i = 0; i < ne; i++) begin
      bit dup;
      int e;
      do begin
        e   = int'($urandom_range(Q - 2, 0));
        dup = 1'b0;
        for (int j = 0; j < i; j++) if (xs[j] == gexp[e]) dup = 1'b1;
      end while (dup);
      xs[i] = gexp[e];
      ys[i] = int'($urandom_range(Q - 1, 0));
    end
    for (int j = 0; j < T; j++) begin
      int s = 0;
      if (j < ne) begin
        for (int i = 0; i < ne; i++) s = s ^ gmul(ys[i], gpow(xs[i], j + 1));
        in_syn[j] = M'(s);
        in_loc[j] = M'(xs[j]);
      end else begin
        in_syn[j] = garbage ? M'($urandom) : '0;
        in_loc[j] = garbage ? M'($urandom) : '0;
      end
    end
    in_valid = 1'b1;
    in_nu    = NUW'(nu_req);
    e_valid  = 1;
    e_nu     = ne;
    e_tag    = tag;
    for (int i = 0; i < T; i++) e_mag[i] = (i < ne) ? ys[i] : 0;
  endtask

  // Idle cycle with random inputs; the held result must not move (R6).
  task automatic idle();
    @(negedge clk);
    compare();
    in_valid = 1'b0;
    in_nu    = NUW'($urandom);
    for (int j = 0; j < T; j++) begin
      in_loc[j] = M'($urandom);
      in_syn[j] = M'($urandom);
    end
    e_valid = 0;
    e_tag   = "R6";
  endtask

  initial begin
    int x;
    x = 1;
    for (int i = 0; i < Q - 1; i++) begin
      gexp[i] = x;
      glog[x] = i;
      x = x << 1;
      if ((x & Q) != 0) x = x ^ POLY;
    end
    glog[0] = 0;

    rst_n    = 1'b0;
    in_valid = 1'b1;
    in_nu    = NUW'(T);
    in_loc   = '1;
    in_syn   = '1;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", int'(out_valid), 0, "reset out_valid");
    chk("R1", int'(out_nu), 0, "reset out_nu");
    for (int k = 0; k < T; k++) chk("R1", int'(out_mag[k]), 0, $sformatf("reset slot %0d", k));
    in_valid = 1'b0;
    @(negedge clk);
    rst_n   = 1'b1;
    e_valid = 0;
    e_nu    = 0;
    e_tag   = "R1";
    for (int i = 0; i < T; i++) e_mag[i] = 0;

    // R2: every error count, clean unused slots
    for (int n = 0; n < 60; n++) send(1 + (n % T), 1'b0, "R2");
    // R6: idle cycles between results
    for (int n = 0; n < 10; n++) begin
      send(1 + int'($urandom_range(T - 1, 0)), 1'b0, "R2");
      idle();
      idle();
    end
    // R4: random contents above nu
    for (int n = 0; n < 40; n++) send(1 + int'($urandom_range(T - 2, 0)), 1'b1, "R4");
    // R5: clamp above T and the empty case
    for (int v = T + 1; v < (1 << NUW); v++) begin
      send(v, 1'b1, "R5");
      send(v, 1'b1, "R5");
    end
    send(0, 1'b1, "R5");
    idle();
    send(0, 1'b0, "R5");
    send(T, 1'b0, "R2");
    idle();
    @(negedge clk);
    compare();

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule